// File: doc/BRIEF.md
# Card Socket Status-Change Register

This block watches the eight input pins of a removable-card socket and keeps a 32-bit status-change register for them. Seven of the pins are voltage-sense 1 and 2, write-protect, card-detect 1 and 2, and battery-voltage-detect 1 and 2. Each has a sticky flag that a transition sets. The eighth pin is the ready/interrupt line. It has two flags that follow its level, and two sticky flags that record its rising and falling edges.

Software reads the register through a small register port. It clears sticky flags by writing ones to them. A second register on the same port holds an interrupt-enable mask. The interrupt-request output is high while any enabled status bit is set. Every pin passes through a two-flop synchronizer inside the block, so the pins may change at any time.

Register bits are numbered with bit 0 as the most significant bit. Status bit n sits at vector index 31-n of `rdData` and `wrData`.

Top module: `sockEventReg`

## Requirements
- R1: After reset, every sticky flag and every enable-mask bit is 0, and `irq` is 0.
- R2: A transition on one of the seven plain pins sets its sticky flag. The flags are bit 16 (index 15) voltage-sense 1, bit 17 (index 14) voltage-sense 2, bit 18 (index 13) write-protect, bit 19 (index 12) card-detect 2, bit 20 (index 11) card-detect 1, bit 21 (index 10) battery-voltage-detect 2, and bit 22 (index 9) battery-voltage-detect 1.
- R3: Bit 24 (index 7) reads 1 while the synchronized ready pin is low. Bit 25 (index 6) reads 1 while it is high. Exactly one of the two reads 1 at any time.
- R4: A rising edge of the ready pin sets bit 26 (index 5). A falling edge sets bit 27 (index 4).
- R5: A set sticky flag stays set until a status write (`regSel`=0) has a 1 at its position. Writing a 0 leaves a flag unchanged.
- R6: Status writes have no effect on bits 24 and 25. These bits change only with the ready pin.
- R7: Reserved bits (0–15, 23, 28–31) always read 0, in both the status and the mask register. Writes to them are ignored.
- R8: If a new transition is detected in the same cycle as a write-one-to-clear to its flag, the flag stays set.
- R9: A write with `regSel`=1 loads the enable mask; only the non-reserved positions (0x0000FEF0) are kept. `irq` is the OR of (status AND mask).
- R10: While the synchronizers fill after reset, no sticky flag is set by the pin levels present at power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinVs1 | input | 1 | Voltage-sense 1 pin (asynchronous) |
| pinVs2 | input | 1 | Voltage-sense 2 pin (asynchronous) |
| pinWp | input | 1 | Write-protect pin (asynchronous) |
| pinCd2 | input | 1 | Card-detect 2 pin (asynchronous) |
| pinCd1 | input | 1 | Card-detect 1 pin (asynchronous) |
| pinBvd2 | input | 1 | Battery-voltage-detect 2 pin (asynchronous) |
| pinBvd1 | input | 1 | Battery-voltage-detect 1 pin (asynchronous) |
| pinRdy | input | 1 | Ready / interrupt pin (asynchronous) |
| regSel | input | 1 | Register select: 0 status, 1 enable mask (read and write) |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Suppose a sticky flag were lost or set falsely. It would show on the next status read and on `irq`. A pin transition shows up three clock edges after the pin changes: two synchronizer stages, then the sticky update. Reads made four cycles after a pin change therefore expose a missing or stray flag. A wrong clear priority shows only when the edge and the clear land on the same clock edge, so the bench aligns that case to the exact edge. A corrupted mask would show on `irq` in the same cycle as the status bit it gates.

// File: rtl/sockPkg.sv
package sockPkg;
  localparam int REG_W      = 32;
  localparam int NUM_PINS   = 8;
  localparam int PLAIN_PINS = 7;
  localparam int SYNC_STAGES = 2;

  // vector index = 31 - register bit number
  localparam int IDX_PLAIN_TOP = 15;  // first plain-pin flag, then downward
  localparam int IDX_RDY_LOW   = 7;
  localparam int IDX_RDY_HIGH  = 6;
  localparam int IDX_RDY_RISE  = 5;
  localparam int IDX_RDY_FALL  = 4;
  localparam int RDY_PIN       = 7;

  localparam logic [REG_W-1:0] STICKY_MASK = 32'h0000_FE30;
  localparam logic [REG_W-1:0] LEVEL_MASK  = 32'h0000_00C0;
  localparam logic [REG_W-1:0] IMPL_MASK   = STICKY_MASK | LEVEL_MASK;

  typedef struct packed {
    logic [REG_W-1:0] clrBits;
    logic             maskWe;
    logic [REG_W-1:0] maskData;
    logic             detectEn;
    logic             readMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/sockSync.sv
module sockSync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else if (s == 0) stageQ[s] <= asyncIn;
        else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/sockCtrl.sv
module sockCtrl
  import sockPkg::*;
#(
  parameter int SYNC_FILL = SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output ctrlStrobes_t     strobes
);
  localparam int WARM_LIMIT = SYNC_FILL + 1;
  localparam int CNT_W = $clog2(WARM_LIMIT + 1);

  logic [CNT_W-1:0] warmCnt;
  logic             warmDone;

  assign warmDone = (warmCnt == CNT_W'(WARM_LIMIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= '0;
    else if (!warmDone) warmCnt <= warmCnt + 1'b1;
  end

  always_comb begin
    strobes.clrBits  = (wrEn && !regSel) ? (wrData & STICKY_MASK) : '0;
    strobes.maskWe   = wrEn && regSel;
    strobes.maskData = wrData & IMPL_MASK;
    strobes.detectEn = warmDone;
    strobes.readMask = regSel;
  end
endmodule

// File: rtl/sockDatapath.sv
module sockDatapath
  import sockPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinsRaw,
  input  ctrlStrobes_t        strobes,
  output logic [REG_W-1:0]    rdData,
  output logic [REG_W-1:0]    statusView,
  output logic [REG_W-1:0]    maskQ,
  output logic                irq
);
  logic [NUM_PINS-1:0] pinsSync;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] diff;
  logic [REG_W-1:0]    events;
  logic [REG_W-1:0]    stickyQ;
  logic [REG_W-1:0]    levelBits;

  sockSync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinsRaw),
    .syncOut (pinsSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else prevQ <= pinsSync;
  end

  assign diff = strobes.detectEn ? (pinsSync ^ prevQ) : '0;

  genvar j;
  generate
    for (j = 0; j < PLAIN_PINS; j++) begin : g_plain
      assign events[IDX_PLAIN_TOP-j] = diff[j];
    end
  endgenerate

  assign events[IDX_RDY_RISE] = diff[RDY_PIN] & pinsSync[RDY_PIN];
  assign events[IDX_RDY_FALL] = diff[RDY_PIN] & ~pinsSync[RDY_PIN];
  assign events[REG_W-1:IDX_PLAIN_TOP+1] = '0;
  assign events[IDX_PLAIN_TOP-PLAIN_PINS] = 1'b0;
  assign events[IDX_RDY_LOW:IDX_RDY_HIGH] = '0;
  assign events[IDX_RDY_FALL-1:0] = '0;

  // new events take priority over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyQ <= '0;
    else stickyQ <= ((stickyQ & ~strobes.clrBits) | events) & STICKY_MASK;
  end

  always_comb begin
    levelBits = '0;
    levelBits[IDX_RDY_LOW]  = ~pinsSync[RDY_PIN];
    levelBits[IDX_RDY_HIGH] = pinsSync[RDY_PIN];
  end

  assign statusView = stickyQ | levelBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else if (strobes.maskWe) maskQ <= strobes.maskData;
  end

  assign rdData = strobes.readMask ? maskQ : statusView;
  assign irq    = |(statusView & maskQ);
endmodule

// File: rtl/sockEventReg.sv
module sockEventReg
  import sockPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinVs1,
  input  logic             pinVs2,
  input  logic             pinWp,
  input  logic             pinCd2,
  input  logic             pinCd1,
  input  logic             pinBvd2,
  input  logic             pinBvd1,
  input  logic             pinRdy,
  input  logic             regSel,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] pinsRaw;
  logic [REG_W-1:0]    statusView;
  logic [REG_W-1:0]    maskQ;

  assign pinsRaw = {pinRdy, pinBvd1, pinBvd2, pinCd1, pinCd2, pinWp, pinVs2, pinVs1};

  sockCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regSel  (regSel),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobes (strobes)
  );

  sockDatapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinsRaw    (pinsRaw),
    .strobes    (strobes),
    .rdData     (rdData),
    .statusView (statusView),
    .maskQ      (maskQ),
    .irq        (irq)
  );
endmodule

// File: rtl/sockEventRegChk.sv
module sockEventRegChk
  import sockPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regSel,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic [REG_W-1:0] statusView,
  input logic [REG_W-1:0] maskQ,
  input logic             irq
);
  // R7: reserved positions never read back as 1
  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~IMPL_MASK) == '0);

  // R3: exactly one ready level bit
  assert_rdy_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(statusView[IDX_RDY_LOW:IDX_RDY_HIGH]) == 1);

  // R9: mask load keeps only implemented positions
  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel) |=> maskQ == ($past(wrData) & IMPL_MASK));

  // R9: no request without an enabled set bit
  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);

  // R5: sticky flags hold unless a one is written to them
  genvar b;
  generate
    for (b = 0; b < REG_W; b++) begin : g_hold
      if (STICKY_MASK[b]) begin : g_on
        assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
          (statusView[b] && !(wrEn && !regSel && wrData[b])) |=> statusView[b]);
      end
    end
  endgenerate
endmodule

bind sockEventReg sockEventRegChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regSel     (regSel),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .statusView (statusView),
  .maskQ      (maskQ),
  .irq        (irq)
);

// File: tb/sockEventReg_tb.sv
module sockEventReg_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pins;  // {rdy, bvd1, bvd2, cd1, cd2, wp, vs2, vs1}
  logic regSel = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq;

  int checks = 0;
  int fails  = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbQ[$];
  event sampleEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sockEventReg u_dut (
    .clk(clk), .rstN(rstN),
    .pinVs1(pins[0]), .pinVs2(pins[1]), .pinWp(pins[2]), .pinCd2(pins[3]),
    .pinCd1(pins[4]), .pinBvd2(pins[5]), .pinBvd1(pins[6]), .pinRdy(pins[7]),
    .regSel(regSel), .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sampleEv);
      while (sbQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        act = it.isIrq ? {31'b0, irq} : rdData;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expectReg(bit sel, logic [31:0] exp, string tag);
    @(negedge clk);
    regSel = sel;
    #1;
    sbQ.push_back('{isIrq: 1'b0, exp: exp, tag: tag});
    -> sampleEv;
  endtask

  task automatic expectIrq(bit exp, string tag);
    @(negedge clk);
    #1;
    sbQ.push_back('{isIrq: 1'b1, exp: {31'b0, exp}, tag: tag});
    -> sampleEv;
  endtask

  task automatic writeReg(bit sel, logic [31:0] d);
    @(negedge clk);
    regSel = sel; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; regSel = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] bitPos;
    pins = 8'b1000_0001;  // vs1 high, ready high at power-up
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(6);
    // R1 R10: no sticky from power-up levels; only ready-high level bit
    expectReg(1'b0, 32'h0000_0040, "R1/R10 status after reset");
    expectReg(1'b1, 32'h0000_0000, "R1 mask after reset");
    expectIrq(1'b0, "R1 irq after reset");

    // R2 R5: each plain pin sets its own flag, cleared by writing one
    for (int j = 0; j < 7; j++) begin
      bitPos = 32'h1 << (15 - j);
      @(negedge clk); pins[j] = ~pins[j];
      waitCyc(4);
      expectReg(1'b0, bitPos | 32'h40, $sformatf("R2 pin %0d flag", j));
      writeReg(1'b0, bitPos);
      expectReg(1'b0, 32'h40, $sformatf("R5 pin %0d cleared", j));
    end

    // R5: writing zero leaves a flag set
    @(negedge clk); pins[0] = ~pins[0];
    waitCyc(4);
    writeReg(1'b0, 32'h0);
    expectReg(1'b0, 32'h0000_8040, "R5 write zero keeps flag");

    // R6 R7: all-ones write clears sticky only, level and reserved stay
    writeReg(1'b0, 32'hFFFF_FFFF);
    expectReg(1'b0, 32'h0000_0040, "R6/R7 all-ones status write");

    // R3 R4: ready falling then rising
    @(negedge clk); pins[7] = 1'b0;
    waitCyc(4);
    expectReg(1'b0, 32'h0000_0090, "R3/R4 ready low and fall flag");
    writeReg(1'b0, 32'h0000_00FF);
    expectReg(1'b0, 32'h0000_0080, "R6 level-low survives write");
    @(negedge clk); pins[7] = 1'b1;
    waitCyc(4);
    expectReg(1'b0, 32'h0000_0060, "R3/R4 ready high and rise flag");
    writeReg(1'b0, 32'h0000_0020);

    // R7 R9: mask register
    writeReg(1'b1, 32'hFFFF_FFFF);
    expectReg(1'b1, 32'h0000_FEF0, "R7/R9 mask reserved bits read 0");
    expectIrq(1'b1, "R9 irq from level bit");
    writeReg(1'b1, 32'h0000_8000);
    expectIrq(1'b0, "R9 irq masked off");
    @(negedge clk); pins[0] = ~pins[0];
    waitCyc(4);
    expectIrq(1'b1, "R9 irq from enabled flag");
    writeReg(1'b0, 32'h0000_8000);
    expectIrq(1'b0, "R9 irq after clear");

    // R8: edge at the same clock edge as a clear keeps the flag
    @(negedge clk); pins[4] = ~pins[4];
    waitCyc(4);
    expectReg(1'b0, 32'h0000_0840, "R8 flag set first");
    @(negedge clk); pins[4] = ~pins[4];  // sync1 next edge, sync2 after, set after that
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); regSel = 1'b0; wrEn = 1'b1; wrData = 32'h0000_0800;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    expectReg(1'b0, 32'h0000_0840, "R8 new edge beats clear");

    waitCyc(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule